// File: doc/BRIEF.md
# Wakeup Edge Interrupt Controller

This block watches eight wakeup input pins and turns a chosen edge on each one into a request flag that stays set. Every pin has its own edge polarity bit and its own pin-function bit. A pin that is not switched to its wakeup function is never sensed. The eight flags are merged into one interrupt request line, and that line always carries the same vector number. An interrupt handler therefore has to read the flag register to find out which pin fired. It then clears the flags it has handled by writing zeros to them.

A group enable input can block the request. So can a global mask bit, which is held in the block. When the CPU accepts the request with a one-cycle acknowledge pulse, the block sets the global mask by itself, so no second wakeup can interrupt the handler. Each pin passes through a two-flop synchronizer before its edge is detected. The edge polarity and pin-function settings used for detection are the ones from the previous cycle, so a change of configuration never produces a flag.

A small state machine drives the request line. It has three states:
- ST_IDLE: no request. It moves to ST_REQUEST when at least one flag is set, the group enable is 1 and the mask is 0.
- ST_REQUEST: the request line is high. It moves to ST_ENTRY when an acknowledge arrives. It returns to ST_IDLE if the condition goes away first.
- ST_ENTRY: the mask has just been set. It always returns to ST_IDLE on the next cycle.

Register map, selected by a 2-bit address:

| Address | Contents |
|---|---|
| 0 | edge polarity, one bit per pin |
| 1 | flags |
| 2 | pin function, one bit per pin |
| 3 | global mask, in bit 0 (bits 7..1 read as 0) |

Top module: `wkirq_ctrl`

## Requirements
- R1: After reset, the edge polarity, flag, pin-function and mask registers all read 0x00, and irq_req is 0.
- R2: A polarity bit of 0 senses a falling edge on its pin and a polarity bit of 1 senses a rising edge. An edge of the other direction leaves the flag clear. A pin change driven before clock edge E1 is not yet visible in the flags after edge E2, and is visible in the flags after edge E3.
- R3: A pin whose pin-function bit (address 2) is 0 never sets its flag, whatever edges occur on it.
- R4: A flag bit stays 1 until software writes 0 to that bit at address 1. Writing 1 to a flag bit has no effect.
- R5: When an edge is detected in the same cycle as a write that clears the same flag bit, the flag ends up set.
- R6: irq_req is 1 in the cycle after a cycle in which some flag is set, grp_en is 1 and the mask is 0. irq_req is 0 whenever grp_en is 0 or the mask is 1, counting the same one-cycle delay.
- R7: irq_vector always equals 9.
- R8: An irq_ack pulse while irq_req is 1 sets the mask bit (address 3, bit 0) at the next clock edge, and irq_req falls at that same edge.
- R9: Writing the polarity or pin-function register while the pins are held steady never sets a flag.
- R10: Setting the mask by acknowledge takes priority over a software write to the mask in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wk_pin | input | 8 | Asynchronous wakeup pins |
| grp_en | input | 1 | Group enable for wakeup requests |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_ack | input | 1 | Acknowledge pulse from the CPU |
| irq_req | output | 1 | Shared interrupt request |
| irq_vector | output | 8 | Fixed vector number |

## Verification
Edge sensing is exercised with a table of vectors. Each vector sets polarity, pin function and a pin transition, and the resulting flags are checked.
- All pins falling, and then all pins rising, show that each polarity selects its own direction.
- The reverse direction shows that opposite edges are ignored.
- A mixed polarity word with half the pins rising and half falling shows that each pin is decoded separately.
- Partial pin-function masks show the gating.

Directed tests then cover the following:
- the edge-versus-clear collision, with the exact cycle of latency;
- configuration changes on steady pins;
- the write-1-has-no-effect rule;
- the request line under every combination of group enable and mask;
- acknowledge setting the mask.

// File: rtl/wkirq_pkg.sv
package wkirq_pkg;

    typedef enum logic [1:0] {
        RA_EDGE = 2'd0,
        RA_FLAG = 2'd1,
        RA_FUNC = 2'd2,
        RA_MASK = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REQUEST = 2'd1,
        ST_ENTRY   = 2'd2
    } req_state_e;

endpackage

// File: rtl/wkirq_sync.sv
module wkirq_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_async,
    output logic [NUM_PINS-1:0] smp_now,
    output logic [NUM_PINS-1:0] smp_prev
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic meta_q;
        logic stable_q;
        logic prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
                prev_q   <= 1'b0;
            end else begin
                meta_q   <= pin_async[i];
                stable_q <= meta_q;
                prev_q   <= stable_q;
            end
        end

        assign smp_now[i]  = stable_q;
        assign smp_prev[i] = prev_q;
    end

endmodule

// File: rtl/wkirq_edge_det.sv
module wkirq_edge_det #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] smp_now,
    input  logic [NUM_PINS-1:0] smp_prev,
    input  logic [NUM_PINS-1:0] pol_q,
    input  logic [NUM_PINS-1:0] func_q,
    output logic [NUM_PINS-1:0] hit
);

    // Settings are delayed by one cycle, so that detection uses the
    // configuration that was in force before a register write.
    logic [NUM_PINS-1:0] pol_d;
    logic [NUM_PINS-1:0] func_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_d  <= '0;
            func_d <= '0;
        end else begin
            pol_d  <= pol_q;
            func_d <= func_q;
        end
    end

    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] fall;

    always_comb begin
        rise = smp_now & ~smp_prev;
        fall = ~smp_now & smp_prev;
        hit  = func_d & ((pol_d & rise) | (~pol_d & fall));
    end

    // R3: a pin that was not in wakeup function one cycle ago cannot hit
    p_func_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & ~$past(func_q)) == '0);

endmodule

// File: rtl/wkirq_regs.sv
module wkirq_regs
    import wkirq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [NUM_PINS-1:0] reg_wdata,
    output logic [NUM_PINS-1:0] reg_rdata,
    input  logic [NUM_PINS-1:0] hit,
    input  logic                take,
    output logic [NUM_PINS-1:0] pol_q,
    output logic [NUM_PINS-1:0] func_q,
    output logic [NUM_PINS-1:0] flag_q,
    output logic                mask_q
);

    logic wr_pol;
    logic wr_flag;
    logic wr_func;
    logic wr_mask;

    always_comb begin
        wr_pol  = reg_we && (reg_addr == RA_EDGE);
        wr_flag = reg_we && (reg_addr == RA_FLAG);
        wr_func = reg_we && (reg_addr == RA_FUNC);
        wr_mask = reg_we && (reg_addr == RA_MASK);
    end

    // Writing a 0 to a flag clears it, and writing a 1 keeps it.
    // A new hit overrides a clear in the same cycle.
    logic [NUM_PINS-1:0] clr_vec;
    logic [NUM_PINS-1:0] flag_n;

    always_comb begin
        clr_vec = wr_flag ? ~reg_wdata : '0;
        flag_n  = (flag_q & ~clr_vec) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q  <= '0;
            func_q <= '0;
            flag_q <= '0;
            mask_q <= 1'b0;
        end else begin
            flag_q <= flag_n;
            if (wr_pol) begin
                pol_q <= reg_wdata;
            end
            if (wr_func) begin
                func_q <= reg_wdata;
            end
            if (take) begin
                mask_q <= 1'b1;
            end else if (wr_mask) begin
                mask_q <= reg_wdata[0];
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_EDGE: reg_rdata = pol_q;
            RA_FLAG: reg_rdata = flag_q;
            RA_FUNC: reg_rdata = func_q;
            default: reg_rdata = {{(NUM_PINS-1){1'b0}}, mask_q};
        endcase
    end

    // R4: without a flag write, no set flag bit may drop
    p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flag |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R5: every hit shows up as a set flag on the next edge, even with a clear
    p_edge_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((flag_q & $past(hit)) == $past(hit)));

    // R10: an acknowledge take always leaves the mask set
    p_take_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> mask_q);

endmodule

// File: rtl/wkirq_req_fsm.sv
module wkirq_req_fsm
    import wkirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic ack,
    output logic req,
    output logic take
);

    req_state_e state_q;
    req_state_e state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pend) state_n = ST_REQUEST;
            end
            ST_REQUEST: begin
                if (ack)       state_n = ST_ENTRY;
                else if (!pend) state_n = ST_IDLE;
            end
            ST_ENTRY: begin
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        req  = (state_q == ST_REQUEST);
        take = (state_q == ST_REQUEST) && ack;
    end

    // R8: an accepted request drops the request line on the next edge
    p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);

    // R6: the request line follows the pending condition of the cycle before
    p_req_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(pend));

endmodule

// File: rtl/wkirq_ctrl.sv
module wkirq_ctrl #(
    parameter int NUM_PINS = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_NUM  = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] wk_pin,
    input  logic                grp_en,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [NUM_PINS-1:0] reg_wdata,
    output logic [NUM_PINS-1:0] reg_rdata,
    input  logic                irq_ack,
    output logic                irq_req,
    output logic [VEC_W-1:0]    irq_vector
);

    localparam logic [VEC_W-1:0] VEC_CODE = VEC_W'(VEC_NUM);

    logic [NUM_PINS-1:0] smp_now;
    logic [NUM_PINS-1:0] smp_prev;
    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] pol_q;
    logic [NUM_PINS-1:0] func_q;
    logic [NUM_PINS-1:0] flag_q;
    logic                mask_q;
    logic                pend;
    logic                take;

    wkirq_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (wk_pin),
        .smp_now   (smp_now),
        .smp_prev  (smp_prev)
    );

    wkirq_edge_det #(.NUM_PINS(NUM_PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_now  (smp_now),
        .smp_prev (smp_prev),
        .pol_q    (pol_q),
        .func_q   (func_q),
        .hit      (hit)
    );

    wkirq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hit       (hit),
        .take      (take),
        .pol_q     (pol_q),
        .func_q    (func_q),
        .flag_q    (flag_q),
        .mask_q    (mask_q)
    );

    assign pend = (|flag_q) && grp_en && !mask_q;

    wkirq_req_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .ack   (irq_ack),
        .req   (irq_req),
        .take  (take)
    );

    assign irq_vector = VEC_CODE;

    // R8: acknowledge of a live request leaves the mask set
    p_ack_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> mask_q);

    // R3: a newly set flag needs the pin function enabled two cycles earlier
    p_flag_func_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q)) & ~$past(func_q, 2)) == '0);

    // R6: the request never stays up while the mask is already set
    p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q && $past(mask_q)) |-> !irq_req);

endmodule

// File: tb/tb_wkirq_ctrl.sv
module tb_wkirq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] wk_pin = 8'h00;
    logic       grp_en = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic [7:0] irq_vector;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wkirq_ctrl dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wk_pin     (wk_pin),
        .grp_en     (grp_en),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_ack    (irq_ack),
        .irq_req    (irq_req),
        .irq_vector (irq_vector)
    );

    // Each vector holds {polarity, function, pins before, pins after, expected flags}
    localparam logic [39:0] VEC [0:5] = '{
        40'h00_FF_FF_00_FF,
        40'hFF_FF_00_FF_FF,
        40'hFF_FF_FF_00_00,
        40'hA5_FF_0F_F0_AA,
        40'h00_3C_FF_00_3C,
        40'h0F_F0_00_FF_00
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state, R7 vector
        rd(2'd0, v); check("R1 polarity", v, 8'h00);
        rd(2'd1, v); check("R1 flags", v, 8'h00);
        rd(2'd2, v); check("R1 function", v, 8'h00);
        rd(2'd3, v); check("R1 mask", v, 8'h00);
        check("R1 irq_req", {7'b0, irq_req}, 8'h00);
        check("R7 vector", irq_vector, 8'd9);

        // R2 / R3 table
        for (int i = 0; i < 6; i++) begin
            wr(2'd0, VEC[i][39:32]);
            wr(2'd2, VEC[i][31:24]);
            @(negedge clk); wk_pin = VEC[i][23:16];
            idle(6);
            wr(2'd1, 8'h00);
            idle(2);
            @(negedge clk); wk_pin = VEC[i][15:8];
            idle(6);
            rd(2'd1, v);
            check((i < 4) ? "R2 table" : "R3 table", v, VEC[i][7:0]);
        end

        // R4: writing 1 has no effect, writing 0 clears
        wr(2'd0, 8'h00); wr(2'd2, 8'hFF);
        @(negedge clk); wk_pin = 8'hFF; idle(5); wr(2'd1, 8'h00);
        @(negedge clk); wk_pin = 8'h00; idle(6);
        wr(2'd1, 8'hFF);
        rd(2'd1, v); check("R4 write one keeps", v, 8'hFF);
        wr(2'd1, 8'h0F);
        rd(2'd1, v); check("R4 write zero clears", v, 8'h0F);
        idle(4);
        rd(2'd1, v); check("R4 sticky", v, 8'h0F);

        // R9: configuration changes on steady pins
        @(negedge clk); wk_pin = 8'h55; idle(6);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hFF);
        wr(2'd2, 8'hFF);
        wr(2'd0, 8'h00);
        wr(2'd0, 8'hAA);
        idle(5);
        rd(2'd1, v); check("R9 no false flag", v, 8'h00);

        // R5 and R2 latency: rising on pin 0 colliding with a clear
        wr(2'd0, 8'hFF);
        @(negedge clk); wk_pin = 8'h54;
        idle(6); wr(2'd1, 8'h00); idle(1);
        @(negedge clk); wk_pin = 8'h55;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        reg_addr = 2'd1; #1;
        check("R2 latency not yet", reg_rdata, 8'h00);
        reg_we = 1'b1; reg_wdata = 8'h00;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        check("R5 edge wins", reg_rdata, 8'h01);

        // R6: request gating
        grp_en = 1'b0; idle(3);
        check("R6 group disabled", {7'b0, irq_req}, 8'h00);
        grp_en = 1'b1; idle(2);
        check("R6 request raised", {7'b0, irq_req}, 8'h01);
        wr(2'd3, 8'h01); idle(2);
        check("R6 mask blocks", {7'b0, irq_req}, 8'h00);
        wr(2'd3, 8'h00); idle(2);
        check("R6 unmasked again", {7'b0, irq_req}, 8'h01);

        // R8 and R10: acknowledge sets mask and drops request, overriding a mask write of 0
        @(negedge clk);
        irq_ack = 1'b1;
        reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h00;
        @(negedge clk);
        irq_ack = 1'b0; reg_we = 1'b0;
        check("R8 request dropped", {7'b0, irq_req}, 8'h00);
        rd(2'd3, v); check("R10 mask set by ack", v, 8'h01);
        idle(4);
        check("R8 stays quiet", {7'b0, irq_req}, 8'h00);
        check("R7 vector steady", irq_vector, 8'd9);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule